// File: doc/BRIEF.md
# Fractional PLL Output Rate Calculator

This block derives the output frequency of a PLL from its reference frequency and the divider settings held in its control fields. A single shared restoring divider does every division in turn, one quotient bit per cycle, so the whole unit costs one 64-bit shift datapath and a small phase sequencer. Software or a monitor pulses `start_i` with the fields present, then waits for the one-cycle `done_o` strobe, when `rate_o`, `err_o` and `ovf_o` are valid. These outputs hold until the next accepted request.

In the default fractional mode the result is `parent * fb / ref`. When the integer-only bit is clear, a 24-bit fractional term `(parent * frac / ref) >> 24` is added to it. The sum is then divided by the first post divider, and that result by the second. Every step truncates. In the alternate mode the three stored fields each hold their divider value minus one. The result is `parent * (fb+1) / (ref+1) / (post_a+1)`, and a bypass bit returns the parent rate unchanged.

Top module: `pll_rate_calc`

## Requirements
- R1: In fractional mode with `int_only_i`=1, the result is floor(floor(floor(parent*fb/ref)/post_a)/post_b). `frac_i` has no effect on it.
- R2: In fractional mode with `int_only_i`=0, floor(floor(parent*frac/ref)/2^24) is added to floor(parent*fb/ref) before the post divisions.
- R3: Each division truncates on its own, so the result can differ from one exact division by the product of the divisors. At every step the divider remainder stays below the divisor.
- R4: With `alt_mode_i`=1 and `bypass_i`=0, the result is floor(floor(parent*(fb+1)/(ref+1))/(post_a+1)). `post_b_i`, `frac_i` and `int_only_i` have no effect.
- R5: With `alt_mode_i`=1 and `bypass_i`=1, `rate_o` equals the parent rate and `done_o` rises one cycle after the start edge.
- R6: In fractional mode, if `ref_i`, `post_a_i` or `post_b_i` is zero, no division runs: `rate_o`=0 and `err_o`=1, with `done_o` one cycle after the start edge. The alternate mode never reports this error.
- R7: Each division takes 65 cycles, and `done_o` is high for exactly one cycle, 1+65*n cycles after the start edge. n is 4 for fractional with the fraction term, 3 for fractional integer-only, and 2 for alternate.
- R8: `rate_o` is the low 32 bits of the final quotient. `ovf_o`=1 exactly when any of the quotient's higher bits is non-zero.
- R9: A `start_i` pulse while a calculation is running is ignored. The running calculation finishes with its original result and timing.
- R10: After reset `rate_o`, `done_o`, `err_o` and `ovf_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request strobe, accepted when idle |
| alt_mode_i | input | 1 | 1 selects the minus-one encoded integer mode |
| bypass_i | input | 1 | Alternate mode: pass parent rate through |
| int_only_i | input | 1 | Fractional mode: 1 drops the fraction term |
| parent_hz_i | input | 32 | Reference (parent) rate |
| fb_i | input | 13 | Feedback divider field |
| ref_i | input | 6 | Reference divider field |
| post_a_i | input | 4 | First post divider field |
| post_b_i | input | 4 | Second post divider field (fractional mode) |
| frac_i | input | 24 | Fraction of the feedback divider, in units of 2^-24 |
| rate_o | output | 32 | Computed rate, truncated to 32 bits |
| done_o | output | 1 | One-cycle strobe when results are valid |
| err_o | output | 1 | Zero divisor detected |
| ovf_o | output | 1 | Final quotient exceeded 32 bits |

## Verification
Some properties are checked on every cycle: the divider remainder stays below its divisor, a new divide is never launched into a busy divider, `done_o` never lasts two cycles, operands stay frozen while a request is in flight, and bypass and zero-divisor requests finish on the next edge with the right value and cause. The arithmetic itself can only be shown by the bench scenarios. These cover the added fraction term, truncation at each step, the plus-one decoding, overflow truncation, and the exact done cycle for each mode.

// File: rtl/prc_pkg.sv
package prc_pkg;

    // Sequencer phases of the rate calculation
    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_PREP   = 3'd1,
        PH_INT    = 3'd2,
        PH_FRAC   = 3'd3,
        PH_POST_A = 3'd4,
        PH_POST_B = 3'd5
    } phase_e;

    // Binary point position of the fractional feedback term
    localparam int unsigned FRAC_POINT = 24;

endpackage

// File: rtl/prc_operands.sv
module prc_operands #(
    parameter int unsigned FB_W  = 13,
    parameter int unsigned REF_W = 6,
    parameter int unsigned PD_W  = 4,
    parameter int unsigned DEN_W = 7
) (
    input  logic             alt_i,
    input  logic [FB_W-1:0]  fb_i,
    input  logic [REF_W-1:0] ref_i,
    input  logic [PD_W-1:0]  pa_i,
    input  logic [PD_W-1:0]  pb_i,
    output logic [FB_W:0]    mul_o,
    output logic [DEN_W-1:0] den_ref_o,
    output logic [DEN_W-1:0] den_pa_o,
    output logic [DEN_W-1:0] den_pb_o,
    output logic             zero_o
);

    logic [DEN_W-1:0] ref_ext;
    logic [DEN_W-1:0] pa_ext;
    logic [DEN_W-1:0] pb_ext;

    always_comb begin
        ref_ext = DEN_W'(ref_i);
        pa_ext  = DEN_W'(pa_i);
        pb_ext  = DEN_W'(pb_i);
        if (alt_i) begin
            // alternate encoding: stored value is the divider minus one
            mul_o     = (FB_W+1)'(fb_i) + 1'b1;
            den_ref_o = ref_ext + 1'b1;
            den_pa_o  = pa_ext + 1'b1;
            den_pb_o  = pb_ext;
            zero_o    = 1'b0;
        end else begin
            mul_o     = (FB_W+1)'(fb_i);
            den_ref_o = ref_ext;
            den_pa_o  = pa_ext;
            den_pb_o  = pb_ext;
            zero_o    = (ref_i == '0) || (pa_i == '0) || (pb_i == '0);
        end
    end

endmodule

// File: rtl/prc_divider.sv
module prc_divider #(
    parameter int unsigned NUM_W = 64,
    parameter int unsigned DEN_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quot_o,
    output logic             fin_o,
    output logic             busy_o
);

    localparam int unsigned CNT_W = $clog2(NUM_W + 1);

    typedef struct packed {
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
        logic [CNT_W-1:0] cnt;
        logic             busy;
        logic             fin;
    } div_st_t;

    div_st_t div_q, div_d;
    logic [DEN_W:0] trial;
    logic [DEN_W:0] diff;
    logic           qbit;

    always_comb begin
        div_d     = div_q;
        div_d.fin = 1'b0;
        trial     = {div_q.rem, div_q.quo[NUM_W-1]};
        diff      = trial - {1'b0, div_q.den};
        qbit      = (trial >= {1'b0, div_q.den});
        if (load_i) begin
            div_d.rem  = '0;
            div_d.quo  = num_i;
            div_d.den  = den_i;
            div_d.cnt  = CNT_W'(NUM_W);
            div_d.busy = 1'b1;
        end else if (div_q.busy) begin
            div_d.rem = qbit ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
            div_d.quo = {div_q.quo[NUM_W-2:0], qbit};
            div_d.cnt = div_q.cnt - 1'b1;
            if (div_q.cnt == CNT_W'(1)) begin
                div_d.busy = 1'b0;
                div_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    assign quot_o = div_q.quo;
    assign fin_o  = div_q.fin;
    assign busy_o = div_q.busy;

    // restoring step keeps the partial remainder below the divisor
    p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_q.busy |-> (div_q.rem < div_q.den));

    // a new divide must never be launched into a running one
    p_load_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> !div_q.busy);

endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc
    import prc_pkg::*;
#(
    parameter int unsigned PR_W   = 32,
    parameter int unsigned FB_W   = 13,
    parameter int unsigned REF_W  = 6,
    parameter int unsigned PD_W   = 4,
    parameter int unsigned FRAC_W = FRAC_POINT,
    parameter int unsigned NUM_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              alt_mode_i,
    input  logic              bypass_i,
    input  logic              int_only_i,
    input  logic [PR_W-1:0]   parent_hz_i,
    input  logic [FB_W-1:0]   fb_i,
    input  logic [REF_W-1:0]  ref_i,
    input  logic [PD_W-1:0]   post_a_i,
    input  logic [PD_W-1:0]   post_b_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [PR_W-1:0]   rate_o,
    output logic              done_o,
    output logic              err_o,
    output logic              ovf_o
);

    localparam int unsigned DEN_W = ((REF_W > PD_W) ? REF_W : PD_W) + 1;

    typedef struct packed {
        logic [PR_W-1:0]   parent;
        logic [FB_W-1:0]   fb;
        logic [REF_W-1:0]  rf;
        logic [PD_W-1:0]   pa;
        logic [PD_W-1:0]   pb;
        logic [FRAC_W-1:0] frac;
        logic              int_only;
        logic              alt;
        logic              byp;
    } ops_t;

    typedef struct packed {
        phase_e           phase;
        ops_t             ops;
        logic [NUM_W-1:0] acc;
        logic [PR_W-1:0]  rate;
        logic             done;
        logic             err;
        logic             ovf;
    } calc_st_t;

    calc_st_t cur_q, cur_d;

    logic [FB_W:0]    op_mul;
    logic [DEN_W-1:0] den_ref;
    logic [DEN_W-1:0] den_pa;
    logic [DEN_W-1:0] den_pb;
    logic             op_zero;

    logic             dv_load;
    logic [NUM_W-1:0] dv_num;
    logic [DEN_W-1:0] dv_den;
    logic [NUM_W-1:0] dv_quot;
    logic             dv_fin;
    logic             dv_busy;

    logic [NUM_W-1:0] prod_int;
    logic [NUM_W-1:0] prod_frac;
    logic [NUM_W-1:0] frac_sum;

    prc_operands #(
        .FB_W (FB_W),
        .REF_W(REF_W),
        .PD_W (PD_W),
        .DEN_W(DEN_W)
    ) ops_i (
        .alt_i    (cur_q.ops.alt),
        .fb_i     (cur_q.ops.fb),
        .ref_i    (cur_q.ops.rf),
        .pa_i     (cur_q.ops.pa),
        .pb_i     (cur_q.ops.pb),
        .mul_o    (op_mul),
        .den_ref_o(den_ref),
        .den_pa_o (den_pa),
        .den_pb_o (den_pb),
        .zero_o   (op_zero)
    );

    prc_divider #(
        .NUM_W(NUM_W),
        .DEN_W(DEN_W)
    ) div_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(dv_load),
        .num_i (dv_num),
        .den_i (dv_den),
        .quot_o(dv_quot),
        .fin_o (dv_fin),
        .busy_o(dv_busy)
    );

    always_comb begin
        prod_int  = NUM_W'(cur_q.ops.parent) * NUM_W'(op_mul);
        prod_frac = NUM_W'(cur_q.ops.parent) * NUM_W'(cur_q.ops.frac);
        frac_sum  = cur_q.acc + (dv_quot >> FRAC_W);
    end

    always_comb begin
        cur_d      = cur_q;
        cur_d.done = 1'b0;
        dv_load    = 1'b0;
        dv_num     = '0;
        dv_den     = '0;
        case (cur_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    cur_d.ops.parent   = parent_hz_i;
                    cur_d.ops.fb       = fb_i;
                    cur_d.ops.rf       = ref_i;
                    cur_d.ops.pa       = post_a_i;
                    cur_d.ops.pb       = post_b_i;
                    cur_d.ops.frac     = frac_i;
                    cur_d.ops.int_only = int_only_i;
                    cur_d.ops.alt      = alt_mode_i;
                    cur_d.ops.byp      = bypass_i;
                    cur_d.phase        = PH_PREP;
                end
            end
            PH_PREP: begin
                if (cur_q.ops.alt && cur_q.ops.byp) begin
                    cur_d.rate  = cur_q.ops.parent;
                    cur_d.err   = 1'b0;
                    cur_d.ovf   = 1'b0;
                    cur_d.done  = 1'b1;
                    cur_d.phase = PH_IDLE;
                end else if (op_zero) begin
                    cur_d.rate  = '0;
                    cur_d.err   = 1'b1;
                    cur_d.ovf   = 1'b0;
                    cur_d.done  = 1'b1;
                    cur_d.phase = PH_IDLE;
                end else begin
                    dv_load     = 1'b1;
                    dv_num      = prod_int;
                    dv_den      = den_ref;
                    cur_d.phase = PH_INT;
                end
            end
            PH_INT: begin
                if (dv_fin) begin
                    cur_d.acc = dv_quot;
                    dv_load   = 1'b1;
                    if (!cur_q.ops.alt && !cur_q.ops.int_only) begin
                        dv_num      = prod_frac;
                        dv_den      = den_ref;
                        cur_d.phase = PH_FRAC;
                    end else begin
                        dv_num      = dv_quot;
                        dv_den      = den_pa;
                        cur_d.phase = PH_POST_A;
                    end
                end
            end
            PH_FRAC: begin
                if (dv_fin) begin
                    dv_load     = 1'b1;
                    dv_num      = frac_sum;
                    dv_den      = den_pa;
                    cur_d.phase = PH_POST_A;
                end
            end
            PH_POST_A: begin
                if (dv_fin) begin
                    if (cur_q.ops.alt) begin
                        cur_d.rate  = dv_quot[PR_W-1:0];
                        cur_d.ovf   = |dv_quot[NUM_W-1:PR_W];
                        cur_d.err   = 1'b0;
                        cur_d.done  = 1'b1;
                        cur_d.phase = PH_IDLE;
                    end else begin
                        dv_load     = 1'b1;
                        dv_num      = dv_quot;
                        dv_den      = den_pb;
                        cur_d.phase = PH_POST_B;
                    end
                end
            end
            PH_POST_B: begin
                if (dv_fin) begin
                    cur_d.rate  = dv_quot[PR_W-1:0];
                    cur_d.ovf   = |dv_quot[NUM_W-1:PR_W];
                    cur_d.err   = 1'b0;
                    cur_d.done  = 1'b1;
                    cur_d.phase = PH_IDLE;
                end
            end
            default: begin
                cur_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    assign rate_o = cur_q.rate;
    assign done_o = cur_q.done;
    assign err_o  = cur_q.err;
    assign ovf_o  = cur_q.ovf;

    // completion strobe lasts a single cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // bypass finishes on the next edge with the parent rate
    p_bypass_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_PREP && cur_q.ops.alt && cur_q.ops.byp)
        |=> (done_o && !err_o && rate_o == $past(cur_q.ops.parent)));

    // an error always has a zero fractional-mode divisor behind it
    p_err_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (!cur_q.ops.alt &&
            (cur_q.ops.rf == '0 || cur_q.ops.pa == '0 || cur_q.ops.pb == '0)));

    // zero reference divisor in fractional mode finishes at once with an error
    p_zero_ref_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase == PH_PREP && !cur_q.ops.alt && cur_q.ops.rf == '0)
        |=> (done_o && err_o && rate_o == '0 && !dv_busy));

    // requests arriving mid-calculation leave the operands untouched
    p_ignore_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase != PH_IDLE && start_i) |=> $stable(cur_q.ops));

endmodule

// File: tb/pll_rate_calc_tb_top.sv
module pll_rate_calc_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        alt_mode_i = 1'b0;
    logic        bypass_i = 1'b0;
    logic        int_only_i = 1'b0;
    logic [31:0] parent_hz_i = '0;
    logic [12:0] fb_i = '0;
    logic [5:0]  ref_i = '0;
    logic [3:0]  post_a_i = '0;
    logic [3:0]  post_b_i = '0;
    logic [23:0] frac_i = '0;
    logic [31:0] rate_o;
    logic        done_o;
    logic        err_o;
    logic        ovf_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pll_rate_calc dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .alt_mode_i (alt_mode_i),
        .bypass_i   (bypass_i),
        .int_only_i (int_only_i),
        .parent_hz_i(parent_hz_i),
        .fb_i       (fb_i),
        .ref_i      (ref_i),
        .post_a_i   (post_a_i),
        .post_b_i   (post_b_i),
        .frac_i     (frac_i),
        .rate_o     (rate_o),
        .done_o     (done_o),
        .err_o      (err_o),
        .ovf_o      (ovf_o)
    );

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference: rate, error and cycles from start edge to done
    function automatic void model(input bit alt, input bit byp, input bit io,
                                  input longint unsigned p, input longint unsigned fb,
                                  input longint unsigned rf, input longint unsigned pa,
                                  input longint unsigned pb, input longint unsigned fr,
                                  output longint unsigned r, output bit e, output int lat);
        longint unsigned t;
        e = 1'b0;
        if (alt) begin
            if (byp) begin
                r = p; lat = 1;
            end else begin
                r = ((p * (fb + 1)) / (rf + 1)) / (pa + 1);
                lat = 1 + 65 * 2;
            end
        end else if (rf == 0 || pa == 0 || pb == 0) begin
            r = 0; e = 1'b1; lat = 1;
        end else begin
            t = (p * fb) / rf;
            if (!io) t = t + (((p * fr) / rf) >> 24);
            r = (t / pa) / pb;
            lat = io ? (1 + 65 * 3) : (1 + 65 * 4);
        end
    endfunction

    task automatic run_case(input string req, input bit alt, input bit byp, input bit io,
                            input longint unsigned p, input longint unsigned fb,
                            input longint unsigned rf, input longint unsigned pa,
                            input longint unsigned pb, input longint unsigned fr,
                            input bit poke);
        longint unsigned r;
        bit e;
        int lat;
        model(alt, byp, io, p, fb, rf, pa, pb, fr, r, e, lat);
        @(negedge clk);
        alt_mode_i = alt; bypass_i = byp; int_only_i = io;
        parent_hz_i = p[31:0]; fb_i = fb[12:0]; ref_i = rf[5:0];
        post_a_i = pa[3:0]; post_b_i = pb[3:0]; frac_i = fr[23:0];
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int k = 1; k <= lat + 2; k++) begin
            @(negedge clk);
            // R7: done exactly once, at the modelled cycle
            check(req, "done", done_o, (k == lat));
            if (poke && k == 5) begin
                // R9: competing request while busy
                parent_hz_i = 32'd12345; fb_i = 13'd7; ref_i = 6'd0;
                alt_mode_i = ~alt; bypass_i = 1'b1; start_i = 1'b1;
            end
            if (poke && k == 6) start_i = 1'b0;
            if (k == lat || k == lat + 2) begin
                check(req, "rate", rate_o, r[31:0]);
                check(req, "err", err_o, e);
                check(req, "ovf", ovf_o, (r >> 32) != 0);
            end
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10", "rate", rate_o, 0);
        check("R10", "done", done_o, 0);
        check("R10", "err", err_o, 0);
        check("R10", "ovf", ovf_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "done after release", done_o, 0);

        // R1: integer-only fractional mode, frac ignored
        run_case("R1", 0, 0, 1, 24000000, 100, 1, 2, 1, 0, 0);
        run_case("R1", 0, 0, 1, 24000000, 100, 1, 2, 1, 24'hABCDEF, 0);
        // R2: fraction term added
        run_case("R2", 0, 0, 0, 24000000, 50, 3, 1, 2, 24'h800000, 0);
        run_case("R2", 0, 0, 0, 26000000, 71, 5, 3, 2, 24'h3A5F91, 0);
        // R3: truncation at every step
        run_case("R3", 0, 0, 1, 1000, 7, 3, 2, 3, 0, 0);
        run_case("R3", 0, 0, 0, 999, 13, 7, 5, 3, 24'hFFFFFF, 0);
        // R4: alternate encoding, extra fields ignored
        run_case("R4", 1, 0, 0, 24000000, 99, 1, 1, 0, 24'h123456, 0);
        run_case("R4", 1, 0, 1, 24000000, 0, 0, 0, 9, 0, 0);
        run_case("R4", 1, 0, 0, 33333333, 8191, 63, 15, 0, 0, 0);
        // R5: bypass
        run_case("R5", 1, 1, 0, 32'hDEADBEEF, 5, 2, 3, 0, 0, 0);
        // R6: zero divisors in each position
        run_case("R6", 0, 0, 0, 24000000, 50, 0, 1, 1, 0, 0);
        run_case("R6", 0, 0, 1, 24000000, 50, 1, 0, 1, 0, 0);
        run_case("R6", 0, 0, 1, 24000000, 50, 1, 1, 0, 0, 0);
        // R8: overflow and truncation to 32 bits
        run_case("R8", 0, 0, 1, 32'hFFFFFFFF, 4095, 1, 1, 1, 0, 0);
        run_case("R8", 1, 0, 0, 32'hFFFFFFFF, 8191, 0, 0, 0, 0, 0);
        // R9: start during a running calculation is ignored
        run_case("R9", 0, 0, 0, 24000000, 50, 3, 1, 2, 24'h800000, 1);
        run_case("R9", 1, 0, 0, 24000000, 99, 1, 1, 0, 0, 1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule